// File: doc/BRIEF.md
# Page Write Buffer with Write Protection

This block sits behind a two-wire serial slave's protocol engine. The engine forwards three kinds of event: a word-address load, a stream of data bytes, and the end of the transaction. Data bytes go into a page-sized staging buffer. A lane is picked by the low bits of a shared word-address pointer. Only those low bits advance after each byte, so a long burst wraps inside its page and overwrites earlier bytes of the same transaction. Nothing reaches the array until the stop event arrives. At stop, every staged lane is written into the array in one clock. A self-timed busy interval then starts, and during it the block takes no strobe from the engine.

A write-protect input guards the array. A parameter picks one of two variants: with the input high, either the whole array is read-only, or only its top quarter is. Blocked bytes are still accepted from the bus but are dropped at commit. If no staged byte survives the protection check, no busy interval starts. A registered read port gives the engine's read path access to the array. The pointer is brought out for current-address reads.

Top module: `page_write_buffer`

## Requirements
- R1: Synchronous active-low reset leaves `busy` low and `ptr` at zero, and it ends a busy interval already in progress.
- R2: `addr_load` copies `addr_in` into `ptr`. Each accepted data byte is staged at lane `ptr[4:0]`, after which only `ptr[4:0]` advances by one and the page bits `ptr[AW-1:5]` stay fixed. After a commit, `ptr` holds the last staged address plus one, wrapped inside the page.
- R3: The lane after lane 31 is lane 0 of the same page, so a burst of more than 32 bytes replaces the bytes staged earlier at the same lanes. The last value wins.
- R4: The array is not changed by data bytes before `stop`. All staged lanes are written at the clock edge that samples `stop`.
- R5: At commit, only the lanes that received a byte in the current transaction change. The other bytes of the page keep their contents.
- R6: A commit that writes at least one byte raises `busy` in the cycle after `stop`. `busy` then stays high for exactly `WRITE_CYCLES` cycles.
- R7: While `busy` is high, `addr_load`, `byte_valid` and `stop` are ignored. `ptr` and the array do not change, and no further busy interval is started.
- R8: With `wp` low, every address of the array is writable.
- R9: In the partial variant (`FULL_PROTECT`=0) with `wp` high, addresses at or above 3/4 of `MEM_BYTES` (0xC00 for 4096 bytes) keep their contents, and lower addresses are written.
- R10: In the full variant (`FULL_PROTECT`=1) with `wp` high, no address is written and no busy interval starts.
- R11: When every staged byte is protected, `stop` starts no busy interval.
- R12: A `stop` after an address load but before any data byte writes nothing and starts no busy interval. `ptr` keeps the loaded address.
- R13: `rd_data` shows the array byte at `rd_addr` one clock after `rd_addr` is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_load | input | 1 | Load `addr_in` into the word pointer and open a transaction |
| addr_in | input | AW | Word address assembled by the protocol engine |
| byte_valid | input | 1 | One received data byte is present on `byte_in` |
| byte_in | input | 8 | Received data byte |
| stop | input | 1 | End of transaction; starts the commit |
| wp | input | 1 | Write-protect level, sampled at commit |
| rd_addr | input | AW | Read address for the engine's read path |
| rd_data | output | 8 | Array byte at the previous cycle's `rd_addr` |
| ptr | output | AW | Shared word-address pointer |
| busy | output | 1 | Self-timed programming interval in progress |

## Verification
The hardest states to reach from the ports are the ones where strobes arrive while the block is busy, and the one where a wrapped burst and the lane mask overlap. Both must leave earlier contents in place. The bench drives a complete address-load, byte and stop sequence straight after a commit, inside the busy window. Afterwards it reads back the page it aimed at and the pointer, to show that nothing moved. It also writes a full known page first, so that later partial and wrapping bursts can show which lanes were left untouched. A second instance built with the full-protect variant gets the same stimulus, so both protection rules are compared under identical traffic.

// File: rtl/pwb_pkg.sv
// Shared types for the page write buffer.
// Assumes: byte-wide data lanes; a page size that is a power of two.
package pwb_pkg;

    typedef logic [7:0] byte_t;

    // Collector state: waiting for an address, or address received.
    typedef enum logic {
        COLL_IDLE = 1'b0,
        COLL_ADDR = 1'b1
    } coll_state_t;

endpackage

// File: rtl/pwb_collect.sv
// Word pointer, staging buffer and lane mask.
// What it does: takes address loads and data bytes from the protocol engine,
//   stages each byte at the pointer's in-page lane, and advances only the
//   in-page bits. It raises commit when stop ends an addressed transaction.
// Assumes: at most one strobe per cycle; priority stop > addr_load > byte;
//   accept is low while the programming interval runs.
module pwb_collect
    import pwb_pkg::*;
#(
    parameter int AW    = 12,
    parameter int LW    = 5,
    localparam int LANES = 1 << LW
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   accept,
    input  logic                   addr_load,
    input  logic [AW-1:0]          addr_in,
    input  logic                   byte_valid,
    input  byte_t                  byte_in,
    input  logic                   stop,
    output logic [AW-1:0]          ptr,
    output logic [LANES-1:0][7:0]  stage,
    output logic [LANES-1:0]       mask,
    output logic                   commit
);

    coll_state_t       state;
    logic [LW-1:0]     lane;
    logic              take_byte;

    assign lane      = ptr[LW-1:0];
    assign take_byte = accept && !stop && !addr_load && byte_valid && (state == COLL_ADDR);
    assign commit    = accept && stop && (state == COLL_ADDR);

    // Pointer, transaction state and lane mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= COLL_IDLE;
            ptr   <= '0;
            mask  <= '0;
        end else if (accept) begin
            if (stop) begin
                state <= COLL_IDLE;
                mask  <= '0;
            end else if (addr_load) begin
                state <= COLL_ADDR;
                ptr   <= addr_in;
                mask  <= '0;
            end else if (take_byte) begin
                mask[lane]    <= 1'b1;
                ptr[LW-1:0]   <= lane + 1'b1;
            end
        end
    end

    // Staging storage; contents only matter where the mask is set.
    always_ff @(posedge clk) begin
        if (take_byte) begin
            stage[lane] <= byte_in;
        end
    end

endmodule

// File: rtl/pwb_guard.sv
// Write-protect decode per lane.
// What it does: turns the staged-lane mask into lane write enables, clearing
//   lanes whose absolute address is protected under the selected variant.
// Assumes: MEM_BYTES is a multiple of four pages.
module pwb_guard #(
    parameter int AW           = 12,
    parameter int LW           = 5,
    parameter int MEM_BYTES    = 4096,
    parameter bit FULL_PROTECT = 1'b0,
    localparam int LANES       = 1 << LW,
    localparam int PROT_BASE   = MEM_BYTES - (MEM_BYTES / 4)
) (
    input  logic [AW-LW-1:0]  page,
    input  logic [LANES-1:0]  mask,
    input  logic              wp,
    output logic [LANES-1:0]  lane_we
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [AW-1:0] addr;
        logic          locked;
        assign addr = {page, LW'(g)};
        if (FULL_PROTECT) begin : g_full
            // Whole array read-only while wp is high.
            assign locked = wp;
        end else begin : g_part
            // Top quarter read-only while wp is high.
            assign locked = wp && (32'(addr) >= PROT_BASE);
        end
        assign lane_we[g] = mask[g] && !locked;
    end

endmodule

// File: rtl/pwb_timer.sv
// Self-timed programming interval.
// What it does: holds busy high for WRITE_CYCLES cycles after a start pulse.
// Assumes: start is only raised while busy is low.
module pwb_timer #(
    parameter int WRITE_CYCLES = 64,
    localparam int CW          = $clog2(WRITE_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    logic [CW-1:0] remain;

    // Down-counter for the remaining programming cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (start) begin
            remain <= CW'(WRITE_CYCLES);
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign busy = (remain != '0);

endmodule

// File: rtl/pwb_array.sv
// Byte array built as one bank per page lane.
// What it does: writes any subset of a page's lanes in one clock; gives a
//   registered single-byte read.
// Assumes: no reset of contents.
module pwb_array
    import pwb_pkg::*;
#(
    parameter int AW     = 12,
    parameter int LW     = 5,
    localparam int LANES = 1 << LW,
    localparam int PAGES = 1 << (AW - LW)
) (
    input  logic                   clk,
    input  logic [LANES-1:0]       we,
    input  logic [AW-LW-1:0]       wpage,
    input  logic [LANES-1:0][7:0]  wdata,
    input  logic [AW-1:0]          rd_addr,
    output byte_t                  rd_data
);

    byte_t lane_rd [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_bank
        byte_t bank [PAGES];
        // Lane write at commit.
        always_ff @(posedge clk) begin
            if (we[g]) begin
                bank[wpage] <= wdata[g];
            end
        end
        assign lane_rd[g] = bank[rd_addr[AW-1:LW]];
    end

    // Registered read from the addressed lane.
    always_ff @(posedge clk) begin
        rd_data <= lane_rd[rd_addr[LW-1:0]];
    end

endmodule

// File: rtl/page_write_buffer.sv
// Page write buffer with write protection (top).
// What it does: stages bytes of a serial write into a page buffer, commits
//   the unprotected staged lanes at stop in one clock, then holds busy for a
//   fixed interval, ignoring engine strobes meanwhile.
// Assumes: MEM_BYTES and PAGE_BYTES are powers of two; wp is stable around stop.
module page_write_buffer
    import pwb_pkg::*;
#(
    parameter int MEM_BYTES    = 4096,
    parameter int PAGE_BYTES   = 32,
    parameter bit FULL_PROTECT = 1'b0,
    parameter int WRITE_CYCLES = 64,
    localparam int AW          = $clog2(MEM_BYTES),
    localparam int LW          = $clog2(PAGE_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          addr_load,
    input  logic [AW-1:0] addr_in,
    input  logic          byte_valid,
    input  logic [7:0]    byte_in,
    input  logic          stop,
    input  logic          wp,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    output logic [AW-1:0] ptr,
    output logic          busy
);

    localparam int LANES = 1 << LW;

    logic [LANES-1:0][7:0] stage;
    logic [LANES-1:0]      mask;
    logic [LANES-1:0]      lane_ok;
    logic [LANES-1:0]      lane_we;
    logic                  commit;
    logic                  start;

    pwb_collect #(.AW(AW), .LW(LW)) u_collect (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (!busy),
        .addr_load  (addr_load),
        .addr_in    (addr_in),
        .byte_valid (byte_valid),
        .byte_in    (byte_in),
        .stop       (stop),
        .ptr        (ptr),
        .stage      (stage),
        .mask       (mask),
        .commit     (commit)
    );

    pwb_guard #(
        .AW(AW), .LW(LW), .MEM_BYTES(MEM_BYTES), .FULL_PROTECT(FULL_PROTECT)
    ) u_guard (
        .page    (ptr[AW-1:LW]),
        .mask    (mask),
        .wp      (wp),
        .lane_we (lane_ok)
    );

    assign lane_we = commit ? lane_ok : '0;
    assign start   = |lane_we;

    pwb_timer #(.WRITE_CYCLES(WRITE_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy)
    );

    pwb_array #(.AW(AW), .LW(LW)) u_array (
        .clk     (clk),
        .we      (lane_we),
        .wpage   (ptr[AW-1:LW]),
        .wdata   (stage),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/pwb_checker.sv
// Protocol checks for the page write buffer, attached by bind.
module pwb_checker #(
    parameter int WRITE_CYCLES = 64,
    parameter bit FULL_PROTECT = 1'b0,
    parameter int AW           = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          stop,
    input logic          wp,
    input logic          busy,
    input logic [AW-1:0] ptr
);

    int run_q;

    // Length of the current run of busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)    run_q <= 0;
        else if (busy) run_q <= run_q + 1;
        else           run_q <= 0;
    end

    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (!busy && ptr == '0));

    a_r6_rise_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop));

    a_r6_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && $past(rst_n)) |-> (run_q == WRITE_CYCLES));

    a_r6_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= WRITE_CYCLES);

    a_r7_ptr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(ptr));

    a_r10_full_lock: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !(FULL_PROTECT && $past(wp)));

endmodule

bind page_write_buffer pwb_checker #(
    .WRITE_CYCLES (WRITE_CYCLES),
    .FULL_PROTECT (FULL_PROTECT),
    .AW           (AW)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .stop  (stop),
    .wp    (wp),
    .busy  (busy),
    .ptr   (ptr)
);

// File: tb/page_write_buffer_test.sv
module page_write_buffer_test;

    localparam int W  = 20;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          addr_load = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic          byte_valid = 1'b0;
    logic [7:0]    byte_in = '0;
    logic          stop = 1'b0;
    logic          wp = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data, rd_data_f;
    logic [AW-1:0] ptr, ptr_f;
    logic          busy, busy_f;

    always #2.5 clk = ~clk;

    page_write_buffer #(.MEM_BYTES(4096), .PAGE_BYTES(32), .FULL_PROTECT(1'b0), .WRITE_CYCLES(W)) uut (
        .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
        .byte_valid(byte_valid), .byte_in(byte_in), .stop(stop), .wp(wp),
        .rd_addr(rd_addr), .rd_data(rd_data), .ptr(ptr), .busy(busy));

    page_write_buffer #(.MEM_BYTES(4096), .PAGE_BYTES(32), .FULL_PROTECT(1'b1), .WRITE_CYCLES(W)) uut_full (
        .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
        .byte_valid(byte_valid), .byte_in(byte_in), .stop(stop), .wp(wp),
        .rd_addr(rd_addr), .rd_data(rd_data_f), .ptr(ptr_f), .busy(busy_f));

    // Vector table: start address, byte count, first data value, wp level.
    typedef struct packed {
        logic [11:0] addr;
        logic [7:0]  cnt;
        logic [7:0]  seed;
        logic        wpv;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{12'h040, 8'd1,  8'h11, 1'b0},  // R2 single byte
        '{12'h05C, 8'd8,  8'h20, 1'b0},  // R3 wraps lane 28 to 3
        '{12'h100, 8'd32, 8'h40, 1'b0},  // R2 full page
        '{12'h200, 8'd40, 8'h80, 1'b0},  // R3 overrun overwrites
        '{12'hC10, 8'd4,  8'h30, 1'b1},  // R9 R11 protected quarter
        '{12'hC10, 8'd4,  8'h31, 1'b0},  // R8 same bytes unprotected
        '{12'h300, 8'd3,  8'h50, 1'b1},  // R9 R10 low region, wp high
        '{12'hFFE, 8'd3,  8'h60, 1'b0}   // R8 top page wrap
    };

    int n_run = 0;
    int n_fail = 0;
    int nb, nbf;
    bit exp_p, exp_f;

    logic [7:0] m_part [4096];
    logic [7:0] m_full [4096];
    bit         k_part [4096];
    bit         k_full [4096];
    logic [7:0] tbuf [32];
    bit         tmask [32];
    logic [11:0] cur_base;
    logic [4:0]  cur_lane;

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        if (busy)   nb++;
        if (busy_f) nbf++;
    endtask

    task automatic t_load(input logic [11:0] a, input logic w);
        wp = w; addr_in = a; addr_load = 1'b1;
        @(negedge clk);
        addr_load = 1'b0;
        cur_base = a & 12'hFE0;
        cur_lane = a[4:0];
        for (int l = 0; l < 32; l++) tmask[l] = 1'b0;
    endtask

    task automatic t_byte(input logic [7:0] d);
        byte_in = d; byte_valid = 1'b1;
        tbuf[cur_lane] = d; tmask[cur_lane] = 1'b1;
        cur_lane = cur_lane + 5'd1;
        @(negedge clk);
        byte_valid = 1'b0;
    endtask

    task automatic t_stop_issue(input string tag);
        stop = 1'b1;
        exp_p = 1'b0; exp_f = 1'b0;
        for (int l = 0; l < 32; l++) begin
            logic [11:0] a;
            a = cur_base | 12'(l);
            if (tmask[l]) begin
                if (!(wp && a >= 12'hC00)) begin
                    m_part[a] = tbuf[l]; k_part[a] = 1'b1; exp_p = 1'b1;
                end
                if (!wp) begin
                    m_full[a] = tbuf[l]; k_full[a] = 1'b1; exp_f = 1'b1;
                end
            end
        end
        nb = 0; nbf = 0;
        tick();
        stop = 1'b0;
        chk(busy == exp_p, tag, "busy after stop (partial)", busy, exp_p);
        chk(busy_f == exp_f, tag, "busy after stop (full)", busy_f, exp_f);
    endtask

    task automatic t_check_page(input logic [11:0] base, input string tag);
        for (int l = 0; l < 32; l++) begin
            logic [11:0] a;
            a = base | 12'(l);
            rd_addr = a;
            @(negedge clk);
            if (k_part[a]) chk(rd_data == m_part[a], tag, "R13 readback partial", rd_data, m_part[a]);
            if (k_full[a]) chk(rd_data_f == m_full[a], tag, "R13 readback full", rd_data_f, m_full[a]);
        end
    endtask

    task automatic t_finish(input string tag);
        while (busy || busy_f) tick();
        chk(nb == (exp_p ? W : 0), "R6", "busy length partial", nb, exp_p ? W : 0);
        chk(nbf == (exp_f ? W : 0), "R6", "busy length full", nbf, exp_f ? W : 0);
        chk(ptr == (cur_base | 12'(cur_lane)), "R2", "pointer after commit", ptr, cur_base | 12'(cur_lane));
        chk(ptr_f == (cur_base | 12'(cur_lane)), "R2", "pointer after commit full", ptr_f, cur_base | 12'(cur_lane));
        t_check_page(cur_base, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4096; i++) begin k_part[i] = 1'b0; k_full[i] = 1'b0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0 && busy_f == 1'b0, "R1", "busy after reset", busy, 0);
        chk(ptr == '0, "R1", "pointer after reset", ptr, 0);

        // Table walk
        for (int v = 0; v < 8; v++) begin
            string tag;
            tag = (VECS[v].wpv) ? "R9" : ((32'(VECS[v].addr[4:0]) + 32'(VECS[v].cnt) > 32) ? "R3" : "R8");
            t_load(VECS[v].addr, VECS[v].wpv);
            for (int i = 0; i < 32'(VECS[v].cnt); i++) t_byte(VECS[v].seed + 8'(i));
            t_stop_issue(VECS[v].wpv ? "R11" : "R6");
            t_finish(tag);
        end
        // R10: full variant stayed idle on the wp-high vectors (counted in t_finish)

        // R5: partial rewrite of a known page keeps other lanes
        t_load(12'h103, 1'b0);
        t_byte(8'hC3); t_byte(8'hC4);
        t_stop_issue("R5");
        t_finish("R5");

        // R4: array unchanged before stop
        t_load(12'h100, 1'b0);
        t_byte(8'hAA); t_byte(8'hAB);
        rd_addr = 12'h100;
        @(negedge clk);
        chk(rd_data == m_part[12'h100], "R4", "array before stop", rd_data, m_part[12'h100]);
        t_stop_issue("R4");
        t_finish("R4");

        // R12: stop with no data
        t_load(12'h123, 1'b0);
        t_stop_issue("R12");
        repeat (3) tick();
        chk(nb == 0, "R12", "no busy on empty stop", nb, 0);
        chk(ptr == 12'h123, "R12", "pointer keeps loaded address", ptr, 12'h123);

        // R7: strobes inside the busy window are ignored
        t_load(12'h400, 1'b0);
        t_byte(8'h77);
        t_stop_issue("R7");
        addr_in = 12'h100; addr_load = 1'b1; tick(); addr_load = 1'b0;
        byte_in = 8'hEE; byte_valid = 1'b1; tick(); byte_valid = 1'b0;
        stop = 1'b1; tick(); stop = 1'b0;
        t_finish("R7");
        rd_addr = 12'h100;
        @(negedge clk);
        chk(rd_data == m_part[12'h100], "R7", "ignored byte left array", rd_data, m_part[12'h100]);
        repeat (3) tick();
        chk(busy == 1'b0, "R7", "no second busy interval", busy, 0);

        // R1: reset ends a busy interval; commit already landed
        t_load(12'h500, 1'b0);
        t_byte(8'h5A);
        t_stop_issue("R1");
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(busy == 1'b0, "R1", "busy cleared by reset", busy, 0);
        chk(ptr == '0, "R1", "pointer cleared by reset", ptr, 0);
        rd_addr = 12'h500;
        @(negedge clk);
        chk(rd_data == 8'h5A, "R4", "commit at stop edge", rd_data, 8'h5A);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule